// File: doc/BRIEF.md
# Receive Descriptor Ring Writer

This block moves received Ethernet frames from a byte stream into host memory. The host prepares a ring of descriptors, each four 32-bit words: a status word at offset 0, a control word holding the buffer size and an end-of-ring flag at offset 4, the buffer address at offset 8 and an unused link word at offset 12. The engine fetches the descriptor at its current position and proceeds only when the host has handed that descriptor over. It then stores the frame into the buffer one word at a time and finally writes a status word that returns the descriptor to the host.

Software sets a run bit and a ring base address. The first start after reset begins at the ring base. Later restarts resume at the descriptor where the engine stopped. The memory side is one request/acknowledge port, one 32-bit word per transfer. Each frame occupies exactly one buffer. A frame larger than its buffer is cut to the buffer size and marked as failed.

Top module: `rxdesc_ring_writer`

## Requirements
- R1: After reset, `mem_req` and `in_ready` are low.
- R2: The engine issues no memory request before `run_en` is first set. The first descriptor read after reset is at `ring_base`.
- R3: Bit 31 of the status word set means the engine owns the descriptor. While it reads a clear bit 31, the engine keeps re-reading that status word. During that time it writes nothing and holds `in_ready` low. It goes on once the host sets the bit.
- R4: Frame bytes are packed little-endian: the first byte of each group of four goes to bits 7:0. The words are written to consecutive addresses starting at the buffer address. In a partial last word the unused bytes are zero. A frame whose length is a multiple of four writes no extra word.
- R5: The status write-back goes to the descriptor's offset 0 and is the last write of the frame. It has bit 31 clear, bit 8 (last segment) set, and the stored byte count, including the 4-byte FCS, in bits 30:16.
- R6: If `in_err` is high on any byte of a frame, bit 15 of that frame's status word is set. Otherwise bit 15 is clear.
- R7: The buffer size is taken from bits 10:0 of the control word. Bytes past that size are accepted and dropped. The length field then equals the size, bit 15 is set, and nothing is written past the buffer.
- R8: After a descriptor whose control bit 25 is set, the next descriptor is at `ring_base`. Otherwise the next descriptor is 16 bytes further on.
- R9: If `run_en` is cleared while the engine waits for ownership, it stops issuing requests. When set again, it resumes at the same descriptor, not at the ring base.
- R10: A memory request stays asserted, with its address, direction and write data unchanged, until `mem_ack`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| run_en | input | 1 | Receive run control |
| ring_base | input | 32 | Byte address of the first descriptor |
| in_valid | input | 1 | Stream byte valid |
| in_data | input | 8 | Stream byte |
| in_last | input | 1 | Final byte of the frame (FCS included) |
| in_err | input | 1 | Error marker for this byte's frame |
| in_ready | output | 1 | Engine accepts a byte |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 32 | Word-aligned byte address |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid with `mem_ack` |
| mem_ack | input | 1 | Request completed |

## Verification
The bench fills the buffer exactly to a word boundary. A design that emits a trailing empty word would overwrite the next word of the buffer. It overruns a five-byte buffer. A design that kept writing would destroy the sentinel words behind that buffer, and one that forgot the error bit would report the frame as clean. It sends a frame into a descriptor that the host still owns. A design that ignored ownership would write over the host's status and data. It also stops and restarts the engine while it waits, to catch a design that jumps back to the ring base or keeps polling after stop. Each frame checks the end-of-ring wrap and the exact position of the length, error and last-segment bits in the status word.

// File: rtl/rxd_pkg.sv
package rxd_pkg;
   typedef enum logic [2:0] {
      ST_IDLE, ST_RD_STAT, ST_RD_CTRL, ST_RD_BUF, ST_RECV, ST_WR_DATA, ST_WR_STAT
   } rxd_state_t;

   localparam int OWN_BIT    = 31;
   localparam int WRAP_BIT   = 25;
   localparam int ERR_BIT    = 15;
   localparam int LAST_BIT   = 8;
   localparam int LEN_LSB    = 16;
   localparam int LEN_FLD_W  = OWN_BIT - LEN_LSB;
   localparam int CTRL_OFS   = 4;
   localparam int BUF_OFS    = 8;
   localparam int DESC_BYTES = 16;
   localparam int WORD_BYTES = 4;
endpackage

// File: rtl/rxd_ring_ptr.sv
module rxd_ring_ptr #(
   parameter int ADDR_W = 32,
   parameter int STRIDE = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [ADDR_W-1:0] base,
   input  logic              step,
   input  logic              wrap,
   output logic [ADDR_W-1:0] cur
);
   logic [ADDR_W-1:0] cur_q;

   always_ff @(posedge clk) begin
      if (!rst_n)    cur_q <= '0;
      else if (load) cur_q <= base;
      else if (step) cur_q <= wrap ? base : cur_q + ADDR_W'(STRIDE);
   end

   assign cur = cur_q;

   a_r8_step_aligned: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !wrap && !load) |=> (cur_q[3:0] == $past(cur_q[3:0])));
endmodule

// File: rtl/rxd_byte_packer.sv
module rxd_byte_packer #(
   parameter bit BIG_ENDIAN = 1'b0
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        clr,
   input  logic        push,
   input  logic [7:0]  din,
   output logic [31:0] word,
   output logic [2:0]  fill
);
   logic [31:0] word_q;
   logic [2:0]  fill_q;
   logic [1:0]  lane;

   generate
      if (BIG_ENDIAN) begin : g_be
         assign lane = 2'd3 - fill_q[1:0];
      end else begin : g_le
         assign lane = fill_q[1:0];
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n || clr) begin
         word_q <= '0;
         fill_q <= '0;
      end else if (push) begin
         word_q[{lane, 3'b000} +: 8] <= din;
         fill_q <= fill_q + 3'd1;
      end
   end

   assign word = word_q;
   assign fill = fill_q;

   a_r4_no_overfill: assert property (@(posedge clk) disable iff (!rst_n)
      push |-> (fill_q < 3'd4));
endmodule

// File: rtl/rxd_status_fmt.sv
module rxd_status_fmt
   import rxd_pkg::*;
#(
   parameter int LEN_W = 11
) (
   input  logic [LEN_W-1:0] len,
   input  logic             err,
   output logic [31:0]      word
);
   always_comb begin
      word                          = '0;
      word[LEN_LSB +: LEN_FLD_W]    = LEN_FLD_W'(len);
      word[ERR_BIT]                 = err;
      word[LAST_BIT]                = 1'b1;
   end
endmodule

// File: rtl/rxdesc_ring_writer.sv
module rxdesc_ring_writer
   import rxd_pkg::*;
#(
   parameter int ADDR_W     = 32,
   parameter int SIZE_W     = 11,
   parameter bit BIG_ENDIAN = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              run_en,
   input  logic [ADDR_W-1:0] ring_base,
   input  logic              in_valid,
   input  logic [7:0]        in_data,
   input  logic              in_last,
   input  logic              in_err,
   output logic              in_ready,
   output logic              mem_req,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [31:0]       mem_wdata,
   input  logic [31:0]       mem_rdata,
   input  logic              mem_ack
);
   generate
      if (SIZE_W < 1 || SIZE_W > LEN_FLD_W) begin : g_bad_size
         $error("SIZE_W must lie between 1 and the length field width");
      end
      if (ADDR_W < 8 || ADDR_W > 32) begin : g_bad_addr
         $error("ADDR_W must lie between 8 and 32");
      end
   endgenerate

   rxd_state_t        state_q, state_d;
   logic              started_q, own_q, wrap_q, err_q, done_q;
   logic [SIZE_W-1:0] size_q, stored_q;
   logic [ADDR_W-1:0] wptr_q, cur_addr;
   logic [31:0]       pack_word, stat_word;
   logic [2:0]        fill, fill_after;
   logic              accept, keep, clr, ptr_load, ptr_step;
   logic              unused_rdata;

   assign unused_rdata = ^mem_rdata;

   assign in_ready   = (state_q == ST_RECV);
   assign accept     = in_valid && in_ready;
   assign keep       = accept && (stored_q < size_q);
   assign fill_after = fill + {2'b00, keep};
   assign clr        = (state_q == ST_WR_DATA) && mem_ack;
   assign ptr_load   = (state_q == ST_IDLE) && run_en && !started_q;
   assign ptr_step   = (state_q == ST_WR_STAT) && mem_ack;

   rxd_ring_ptr #(.ADDR_W(ADDR_W), .STRIDE(DESC_BYTES)) u_ptr (
      .clk(clk), .rst_n(rst_n), .load(ptr_load), .base(ring_base),
      .step(ptr_step), .wrap(wrap_q), .cur(cur_addr));

   rxd_byte_packer #(.BIG_ENDIAN(BIG_ENDIAN)) u_pack (
      .clk(clk), .rst_n(rst_n), .clr(clr), .push(keep), .din(in_data),
      .word(pack_word), .fill(fill));

   rxd_status_fmt #(.LEN_W(SIZE_W)) u_fmt (
      .len(stored_q), .err(err_q), .word(stat_word));

   // memory port decode
   always_comb begin
      mem_req   = 1'b0;
      mem_we    = 1'b0;
      mem_addr  = cur_addr;
      mem_wdata = '0;
      unique case (state_q)
         ST_RD_STAT: mem_req = 1'b1;
         ST_RD_CTRL: begin mem_req = 1'b1; mem_addr = cur_addr + ADDR_W'(CTRL_OFS); end
         ST_RD_BUF:  begin mem_req = 1'b1; mem_addr = cur_addr + ADDR_W'(BUF_OFS); end
         ST_WR_DATA: begin mem_req = 1'b1; mem_we = 1'b1; mem_addr = wptr_q; mem_wdata = pack_word; end
         ST_WR_STAT: begin mem_req = 1'b1; mem_we = 1'b1; mem_wdata = stat_word; end
         default: ;
      endcase
   end

   // sequencing
   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ST_IDLE:    if (run_en) state_d = ST_RD_STAT;
         ST_RD_STAT: if (mem_ack) begin
                        if (mem_rdata[OWN_BIT]) state_d = ST_RD_CTRL;
                        else if (!run_en)       state_d = ST_IDLE;
                     end
         ST_RD_CTRL: if (mem_ack) state_d = ST_RD_BUF;
         ST_RD_BUF:  if (mem_ack) state_d = ST_RECV;
         ST_RECV:    if (accept) begin
                        if (in_last)                 state_d = (fill_after != 3'd0) ? ST_WR_DATA : ST_WR_STAT;
                        else if (fill_after == 3'd4) state_d = ST_WR_DATA;
                     end
         ST_WR_DATA: if (mem_ack) state_d = done_q ? ST_WR_STAT : ST_RECV;
         ST_WR_STAT: if (mem_ack) state_d = run_en ? ST_RD_STAT : ST_IDLE;
         default:    state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q   <= ST_IDLE;
         started_q <= 1'b0;
         own_q     <= 1'b0;
         wrap_q    <= 1'b0;
         err_q     <= 1'b0;
         done_q    <= 1'b0;
         size_q    <= '0;
         stored_q  <= '0;
         wptr_q    <= '0;
      end else begin
         state_q <= state_d;
         if (ptr_load) started_q <= 1'b1;
         if (state_q == ST_RD_STAT && mem_ack && mem_rdata[OWN_BIT]) own_q <= 1'b1;
         if (state_q == ST_RD_CTRL && mem_ack) begin
            size_q <= mem_rdata[SIZE_W-1:0];
            wrap_q <= mem_rdata[WRAP_BIT];
         end
         if (state_q == ST_RD_BUF && mem_ack) begin
            wptr_q   <= mem_rdata[ADDR_W-1:0];
            stored_q <= '0;
            err_q    <= 1'b0;
            done_q   <= 1'b0;
         end
         if (accept) begin
            if (keep) stored_q <= stored_q + SIZE_W'(1);
            err_q <= err_q | in_err | !keep;
            if (in_last) done_q <= 1'b1;
         end
         if (clr)      wptr_q <= wptr_q + ADDR_W'(WORD_BYTES);
         if (ptr_step) own_q  <= 1'b0;
      end
   end

   a_r1_quiet_after_reset: assert property (@(posedge clk)
      !rst_n |=> (!mem_req && !in_ready));

   a_r2_no_req_before_start: assert property (@(posedge clk) disable iff (!rst_n)
      !started_q |-> !mem_req);

   a_r3_write_only_owned: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && mem_we) |-> own_q);

   a_r3_accept_only_owned: assert property (@(posedge clk) disable iff (!rst_n)
      in_ready |-> own_q);

   a_r5_status_bits: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && mem_we && mem_addr == cur_addr) |-> (!mem_wdata[OWN_BIT] && mem_wdata[LAST_BIT]));

   a_r7_len_in_buffer: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_WR_STAT) |-> (mem_wdata[LEN_LSB +: SIZE_W] <= size_q));

   a_r10_hold_request: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));
endmodule

// File: tb/test_rxdesc_ring_writer.sv
`timescale 1ns/1ps
module test_rxdesc_ring_writer;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        run_en = 1'b0;
   logic [31:0] ring_base = 32'h100;
   logic        in_valid = 1'b0, in_last = 1'b0, in_err = 1'b0;
   logic [7:0]  in_data = '0;
   logic        in_ready, mem_req, mem_we, mem_ack;
   logic [31:0] mem_addr, mem_wdata, mem_rdata;

   always #2 clk = ~clk;

   rxdesc_ring_writer i_rxdesc_ring_writer (
      .clk(clk), .rst_n(rst_n), .run_en(run_en), .ring_base(ring_base),
      .in_valid(in_valid), .in_data(in_data), .in_last(in_last), .in_err(in_err),
      .in_ready(in_ready), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
      .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack));

   // memory model: one-cycle acknowledge, host write port
   logic [31:0] mem [0:255];
   logic        ack_r = 1'b0;
   logic [31:0] rdata_r = '0;
   logic        host_we = 1'b0;
   logic [31:0] host_addr = '0, host_data = '0;
   int          n_req = 0, n_writes = 0, hold_viol = 0;
   logic [31:0] last_waddr = '0, prev_addr = '0;
   logic        prev_pend = 1'b0;

   assign mem_ack   = ack_r;
   assign mem_rdata = rdata_r;

   always @(posedge clk) begin
      if (host_we) mem[host_addr[9:2]] <= host_data;
      if (!rst_n) begin
         ack_r     <= 1'b0;
         prev_pend <= 1'b0;
      end else begin
         ack_r <= 1'b0;
         if (prev_pend && (!mem_req || mem_addr != prev_addr)) hold_viol <= hold_viol + 1;
         prev_pend <= mem_req && !ack_r;
         prev_addr <= mem_addr;
         if (mem_req && !ack_r) begin
            ack_r <= 1'b1;
            n_req <= n_req + 1;
            if (mem_we) begin
               mem[mem_addr[9:2]] <= mem_wdata;
               n_writes   <= n_writes + 1;
               last_waddr <= mem_addr;
            end else begin
               rdata_r <= mem[mem_addr[9:2]];
            end
         end
      end
   end

   int errs = 0, checks = 0;
   logic sent_done = 1'b0;

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errs++;
         $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic host_wr(input logic [31:0] a, input logic [31:0] d);
      @(negedge clk);
      host_we = 1'b1; host_addr = a; host_data = d;
      @(negedge clk);
      host_we = 1'b0;
   endtask

   task automatic send_frame(input int n, input int errpos, input logic [7:0] base);
      @(negedge clk);
      for (int i = 0; i < n; i++) begin
         in_valid = 1'b1;
         in_data  = base + 8'(i);
         in_last  = (i == n - 1);
         in_err   = (i == errpos);
         while (!in_ready) @(negedge clk);
         @(negedge clk);
      end
      in_valid = 1'b0; in_last = 1'b0; in_err = 1'b0;
   endtask

   task automatic wait_done(input logic [31:0] a);
      int k = 0;
      while (mem[a[9:2]][31] && k < 3000) begin
         @(negedge clk);
         k++;
      end
      repeat (4) @(negedge clk);
   endtask

   task automatic t_reset;
      for (int i = 0; i < 256; i++) host_wr(32'(i * 4), 32'h0);
      host_wr(32'h100, 32'h8000_0000); host_wr(32'h104, 32'h0000_0040); host_wr(32'h108, 32'h200);
      host_wr(32'h110, 32'h8000_0000); host_wr(32'h114, 32'h0000_0040); host_wr(32'h118, 32'h280);
      host_wr(32'h120, 32'h8000_0000); host_wr(32'h124, 32'h0200_0005); host_wr(32'h128, 32'h300);
      for (int i = 0; i < 4; i++) host_wr(32'h300 + 32'(i * 4), 32'hDEAD_BEEF);
      chk("R1 mem_req after reset", {31'b0, mem_req}, 32'h0);
      chk("R1 in_ready after reset", {31'b0, in_ready}, 32'h0);
      @(negedge clk); rst_n = 1'b1;
      repeat (20) @(negedge clk);
      chk("R2 no request while stopped", 32'(n_req), 32'h0);
   endtask

   task automatic t_basic;
      run_en = 1'b1;
      send_frame(7, -1, 8'h10);
      wait_done(32'h100);
      chk("R4 word0", mem[8'h80], 32'h1312_1110);
      chk("R4 partial word1 zero fill", mem[8'h81], 32'h0016_1514);
      chk("R5 status word", mem[8'h40], 32'h0007_0100);
      chk("R5 status is last write", last_waddr, 32'h100);
      chk("R2 first descriptor at base, write count", 32'(n_writes), 32'd3);
   endtask

   task automatic t_error;
      send_frame(4, 2, 8'h20);
      wait_done(32'h110);
      chk("R4 exact word", mem[8'hA0], 32'h2322_2120);
      chk("R4 no extra word", mem[8'hA1], 32'h0);
      chk("R6 error status", mem[8'h44], 32'h0004_8100);
   endtask

   task automatic t_trunc;
      send_frame(9, -1, 8'h30);
      wait_done(32'h120);
      chk("R7 word0", mem[8'hC0], 32'h3332_3130);
      chk("R7 word1", mem[8'hC1], 32'h0000_0034);
      chk("R7 beyond buffer untouched", mem[8'hC2], 32'hDEAD_BEEF);
      chk("R7 truncated status", mem[8'h48], 32'h0005_8100);
   endtask

   task automatic t_wrap;
      host_wr(32'h100, 32'h8000_0000);
      send_frame(1, -1, 8'h41);
      wait_done(32'h100);
      chk("R8 wrap data at base buffer", mem[8'h80], 32'h0000_0041);
      chk("R8 wrap status at base", mem[8'h40], 32'h0001_0100);
   endtask

   task automatic t_stall;
      int w0;
      sent_done = 1'b0;
      w0 = n_writes;
      fork
         begin send_frame(5, -1, 8'h50); sent_done = 1'b1; end
      join_none
      repeat (60) @(negedge clk);
      chk("R3 in_ready low while not owned", {31'b0, in_ready}, 32'h0);
      chk("R3 no writes while not owned", 32'(n_writes - w0), 32'h0);
      chk("R3 host status untouched", mem[8'h44], 32'h0004_8100);
      host_wr(32'h110, 32'h8000_0000);
      while (!sent_done) @(negedge clk);
      wait_done(32'h110);
      chk("R3 status after handover", mem[8'h44], 32'h0005_0100);
      chk("R3 data after handover", mem[8'hA0], 32'h5352_5150);
   endtask

   task automatic t_stop;
      int r0;
      run_en = 1'b0;
      repeat (10) @(negedge clk);
      r0 = n_req;
      repeat (40) @(negedge clk);
      chk("R9 no requests after stop", 32'(n_req - r0), 32'h0);
      chk("R9 mem_req low after stop", {31'b0, mem_req}, 32'h0);
      host_wr(32'h120, 32'h8000_0000);
      run_en = 1'b1;
      send_frame(2, -1, 8'h60);
      wait_done(32'h120);
      chk("R9 resume at current descriptor data", mem[8'hC0], 32'h0000_6160);
      chk("R9 resume at current descriptor status", mem[8'h48], 32'h0002_0100);
      chk("R10 request held until ack", 32'(hold_viol), 32'h0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errs++; checks++;
      $display("FAIL watchdog expired, all requirements unfinished");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end

   initial begin
      t_reset();
      t_basic();
      t_error();
      t_trunc();
      t_wrap();
      t_stall();
      t_stop();
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end
endmodule